// File: doc/BRIEF.md
# Video Pixel Output Formatter

This block places an internal pixel stream onto a 24-pin video output bus. The stream carries either 4:2:2 luma and chroma words of up to 12 bits or 4:4:4 RGB words of 8 bits per colour. An 8-bit format code picks how the components are spread over the pins. Each pin also has an enable bit. A pin the chosen format does not use has its enable low and reads zero, which models a high-impedance pin.

The block runs on one clock, `clk_i`, and takes one input word per cycle. A phase bit alternates between even and odd words. In the narrow 4:2:2 formats, which use one component lane, even words carry chroma and odd words carry luma. In the double-data-rate formats the block also drives `pclk_o`, an output clock at half the `clk_i` rate. It is high while an even word is on the bus and low while an odd word is on the bus, so two words share one output clock period. The phase is re-aligned at every rising edge of DE, so the first active word of a line is always even. A new format code is taken only at a DE rising edge, so the lane layout never changes in the middle of a line.

The data, the enables, the output clock, DE, HS and VS all pass through one register stage, so the syncs stay aligned with the pixels.

Top module: `pix_out_fmt`

## Requirements
- R1: While reset is held and after reset until the first DE rising edge, `oe_o`, `bus_o`, `pclk_o`, `de_o`, `hs_o` and `vs_o` are all zero.
- R2: Code 0x00 (8-bit single rate) drives bus[15:8] with the low byte of the component selected by phase (chroma on even words, luma on odd words). `oe_o` is 0x00FF00.
- R3: Code 0x0A (12-bit single rate) puts bits [11:4] of the phase-selected component on bus[15:8] and bits [3:0] on bus[23:20]. `oe_o` is 0xF0FF00.
- R4: Code 0x80 (16-bit single rate) puts luma[7:0] on bus[15:8] and chroma[7:0] on bus[7:0]. `oe_o` is 0x00FFFF.
- R5: Code 0x8A (24-bit single rate, 12-bit components) places luma[11:4] on bus[15:8], luma[3:0] on bus[23:20], chroma[11:4] on bus[7:0] and chroma[3:0] on bus[19:16]. `oe_o` is 0xFFFFFF.
- R6: Code 0x40 (RGB single rate) places red on bus[23:16], green on bus[15:8] and blue on bus[7:0]. `oe_o` is 0xFFFFFF.
- R7: Codes 0x20 and 0x2A (double rate 4:2:2) use the same lanes and the same enables as 0x00 and 0x0A. `pclk_o` is 1 with the chroma (even) word and 0 with the luma (odd) word.
- R8: Code 0x60 (double rate RGB) uses the lanes of 0x40. `pclk_o` is 1 while the even pixel is on the bus and 0 while the odd pixel is on the bus.
- R9: In every single-rate format `pclk_o` stays 0.
- R10: Any other code sets all 24 bits of `oe_o` and `bus_o` to zero.
- R11: A change of `fmt_sel_i` has no effect on `oe_o` until the next rising edge of `de_i`. The code present in that cycle applies to that first active word.
- R12: Each output word, with its enables and `pclk_o`, appears one clock after its input. `de_o`, `hs_o` and `vs_o` are the inputs delayed by that same one clock.
- R13: A bus bit whose enable is low reads 0, and `oe_o` is always one of the lane sets listed in R2 to R6 or zero.
- R14: The first word after a DE rising edge is an even word (chroma, and `pclk_o` high in a double-rate format), whatever the length of the blanking before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_sel_i | input | 8 | Format code |
| de_i | input | 1 | Active video flag |
| hs_i | input | 1 | Horizontal sync |
| vs_i | input | 1 | Vertical sync |
| y_i | input | 12 | Luma component |
| c_i | input | 12 | Chroma component (Cb/Cr alternating) |
| r_i | input | 8 | Red component |
| g_i | input | 8 | Green component |
| b_i | input | 8 | Blue component |
| bus_o | output | 24 | Output pixel bus |
| oe_o | output | 24 | Per-pin output enable |
| pclk_o | output | 1 | Half-rate output clock for double-rate formats |
| de_o | output | 1 | Delayed active video flag |
| hs_o | output | 1 | Delayed horizontal sync |
| vs_o | output | 1 | Delayed vertical sync |

## Verification
Each of the eight valid codes and one invalid code is driven with luma and chroma words whose nibbles all differ. A nibble that lands in the wrong lane, in the wrong order or at the wrong phase therefore gives a different bus value. The chroma-first order in the narrow formats is checked on both phases, and the double-rate RGB format is given distinct even and odd pixels to confirm the half in which each one appears. Directed sequences change the format code in the middle of a line and during blanking. Other sequences vary the blanking length before DE to test phase re-alignment, and pulse HS and VS for one cycle to confirm the single-clock delay.

// File: rtl/pof_pkg.sv
package pof_pkg;
  localparam int BUS_W = 24;
  localparam int CMP_W = 12;
  localparam int RGB_W = 8;
  localparam int NIB_W = CMP_W - RGB_W;
  localparam int SEL_W = 8;

  typedef enum logic [2:0] {
    LN_OFF, LN_8, LN_12, LN_16, LN_24Y, LN_RGB
  } lane_e;

  typedef struct packed {
    lane_e lane;
    logic  ddr;
  } mode_t;

  function automatic mode_t decode_fmt(logic [SEL_W-1:0] code);
    mode_t m;
    m.ddr = 1'b0;
    unique case (code)
      8'h00: m.lane = LN_8;
      8'h0A: m.lane = LN_12;
      8'h80: m.lane = LN_16;
      8'h8A: m.lane = LN_24Y;
      8'h40: m.lane = LN_RGB;
      8'h20: begin m.lane = LN_8;   m.ddr = 1'b1; end
      8'h2A: begin m.lane = LN_12;  m.ddr = 1'b1; end
      8'h60: begin m.lane = LN_RGB; m.ddr = 1'b1; end
      default: m.lane = LN_OFF;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/pof_mode_ctl.sv
module pof_mode_ctl
  import pof_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             de_i,
  input  logic [SEL_W-1:0] sel_i,
  output mode_t            mode_o,
  output logic             phase_o
);
  logic  de_q, ph_q, de_rise;
  mode_t mode_q;

  assign de_rise = de_i & ~de_q;
  // new code applies to the first active word itself
  assign mode_o  = de_rise ? decode_fmt(sel_i) : mode_q;
  // realign: first word after DE rise is even
  assign phase_o = de_rise ? 1'b0 : ~ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      de_q   <= 1'b0;
      ph_q   <= 1'b1;
      mode_q <= '{lane: LN_OFF, ddr: 1'b0};
    end else begin
      de_q   <= de_i;
      ph_q   <= phase_o;
      mode_q <= mode_o;
    end
  end
endmodule

// File: rtl/pof_lane_map.sv
module pof_lane_map
  import pof_pkg::*;
(
  input  mode_t            mode_i,
  input  logic             phase_i,
  input  logic [CMP_W-1:0] y_i,
  input  logic [CMP_W-1:0] c_i,
  input  logic [RGB_W-1:0] r_i,
  input  logic [RGB_W-1:0] g_i,
  input  logic [RGB_W-1:0] b_i,
  output logic [BUS_W-1:0] bus_o,
  output logic [BUS_W-1:0] oe_o
);
  localparam int LO = 0;
  localparam int MD = RGB_W;
  localparam int HI = 2 * RGB_W;
  localparam int NH = BUS_W - NIB_W;

  logic [CMP_W-1:0] comp;
  assign comp = phase_i ? y_i : c_i;

  always_comb begin
    bus_o = '0;
    oe_o  = '0;
    unique case (mode_i.lane)
      LN_8: begin
        bus_o[MD +: RGB_W] = comp[RGB_W-1:0];
        oe_o [MD +: RGB_W] = '1;
      end
      LN_12: begin
        bus_o[MD +: RGB_W] = comp[CMP_W-1:NIB_W];
        bus_o[NH +: NIB_W] = comp[NIB_W-1:0];
        oe_o [MD +: RGB_W] = '1;
        oe_o [NH +: NIB_W] = '1;
      end
      LN_16: begin
        bus_o[MD +: RGB_W] = y_i[RGB_W-1:0];
        bus_o[LO +: RGB_W] = c_i[RGB_W-1:0];
        oe_o [LO +: 2*RGB_W] = '1;
      end
      LN_24Y: begin
        bus_o[MD +: RGB_W] = y_i[CMP_W-1:NIB_W];
        bus_o[NH +: NIB_W] = y_i[NIB_W-1:0];
        bus_o[LO +: RGB_W] = c_i[CMP_W-1:NIB_W];
        bus_o[HI +: NIB_W] = c_i[NIB_W-1:0];
        oe_o = '1;
      end
      LN_RGB: begin
        bus_o[HI +: RGB_W] = r_i;
        bus_o[MD +: RGB_W] = g_i;
        bus_o[LO +: RGB_W] = b_i;
        oe_o = '1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pix_out_fmt.sv
module pix_out_fmt
  import pof_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] fmt_sel_i,
  input  logic             de_i,
  input  logic             hs_i,
  input  logic             vs_i,
  input  logic [CMP_W-1:0] y_i,
  input  logic [CMP_W-1:0] c_i,
  input  logic [RGB_W-1:0] r_i,
  input  logic [RGB_W-1:0] g_i,
  input  logic [RGB_W-1:0] b_i,
  output logic [BUS_W-1:0] bus_o,
  output logic [BUS_W-1:0] oe_o,
  output logic             pclk_o,
  output logic             de_o,
  output logic             hs_o,
  output logic             vs_o
);
  mode_t            mode;
  logic             phase;
  logic [BUS_W-1:0] bus_d, oe_d;

  pof_mode_ctl u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .de_i    (de_i),
    .sel_i   (fmt_sel_i),
    .mode_o  (mode),
    .phase_o (phase)
  );

  pof_lane_map u_map (
    .mode_i  (mode),
    .phase_i (phase),
    .y_i     (y_i),
    .c_i     (c_i),
    .r_i     (r_i),
    .g_i     (g_i),
    .b_i     (b_i),
    .bus_o   (bus_d),
    .oe_o    (oe_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_o  <= '0;
      oe_o   <= '0;
      pclk_o <= 1'b0;
      de_o   <= 1'b0;
      hs_o   <= 1'b0;
      vs_o   <= 1'b0;
    end else begin
      bus_o  <= bus_d;
      oe_o   <= oe_d;
      pclk_o <= mode.ddr & ~phase;
      de_o   <= de_i;
      hs_o   <= hs_i;
      vs_o   <= vs_i;
    end
  end
endmodule

// File: rtl/pix_out_fmt_chk.sv
module pix_out_fmt_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        de_i,
  input logic        hs_i,
  input logic        vs_i,
  input logic [23:0] bus_o,
  input logic [23:0] oe_o,
  input logic        pclk_o,
  input logic        de_o,
  input logic        hs_o,
  input logic        vs_o
);
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_o & ~oe_o) == 24'h0); // R13

  AST_OE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o inside {24'h000000, 24'h00FF00, 24'hF0FF00, 24'h00FFFF, 24'hFFFFFF}); // R13

  AST_SYNC_DLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (hs_o == $past(hs_i)) && (vs_o == $past(vs_i)) && (de_o == $past(de_i))); // R12

  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(de_i) |=> $stable(oe_o)); // R11

  AST_PCLK_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pclk_o && $past(pclk_o)) |-> (de_o && !$past(de_o))); // R14

  AST_PCLK_SDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pclk_o |-> oe_o inside {24'h00FF00, 24'hF0FF00, 24'hFFFFFF}); // R9
endmodule

bind pix_out_fmt pix_out_fmt_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .de_i   (de_i),
  .hs_i   (hs_i),
  .vs_i   (vs_i),
  .bus_o  (bus_o),
  .oe_o   (oe_o),
  .pclk_o (pclk_o),
  .de_o   (de_o),
  .hs_o   (hs_o),
  .vs_o   (vs_o)
);

// File: tb/sim_pix_out_fmt.sv
`timescale 1ns/1ps
module sim_pix_out_fmt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sel = 8'h00;
  logic        de = 1'b0, hs = 1'b0, vs = 1'b0;
  logic [11:0] y = '0, c = '0;
  logic [7:0]  r = '0, g = '0, b = '0;
  logic [23:0] bus, oe;
  logic        pclk, de_q, hs_q, vs_q;
  int          n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  pix_out_fmt u0 (
    .clk_i(clk), .rst_ni(rst_n), .fmt_sel_i(sel), .de_i(de), .hs_i(hs), .vs_i(vs),
    .y_i(y), .c_i(c), .r_i(r), .g_i(g), .b_i(b),
    .bus_o(bus), .oe_o(oe), .pclk_o(pclk), .de_o(de_q), .hs_o(hs_q), .vs_o(vs_q)
  );

  typedef struct packed {
    logic [7:0]  code;
    logic [11:0] y, c;
    logic [7:0]  r, g, b;
    logic [23:0] e0, e1, eoe;
    logic        ep;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 12'hABC, 12'h123, 8'h00, 8'h00, 8'h00, 24'h002300, 24'h00BC00, 24'h00FF00, 1'b0}, // R2
    '{8'h0A, 12'hABC, 12'h123, 8'h00, 8'h00, 8'h00, 24'h301200, 24'hC0AB00, 24'hF0FF00, 1'b0}, // R3
    '{8'h80, 12'h5E7, 12'h934, 8'h00, 8'h00, 8'h00, 24'h00E734, 24'h00E734, 24'h00FFFF, 1'b0}, // R4
    '{8'h8A, 12'hABC, 12'h123, 8'h00, 8'h00, 8'h00, 24'hC3AB12, 24'hC3AB12, 24'hFFFFFF, 1'b0}, // R5
    '{8'h40, 12'h000, 12'h000, 8'h5A, 8'hC3, 8'h96, 24'h5AC396, 24'h5AC396, 24'hFFFFFF, 1'b0}, // R6
    '{8'h20, 12'hABC, 12'h123, 8'h00, 8'h00, 8'h00, 24'h002300, 24'h00BC00, 24'h00FF00, 1'b1}, // R7
    '{8'h2A, 12'hABC, 12'h123, 8'h00, 8'h00, 8'h00, 24'h301200, 24'hC0AB00, 24'hF0FF00, 1'b1}, // R7
    '{8'h60, 12'h000, 12'h000, 8'h11, 8'h22, 8'h33, 24'h112233, 24'h112233, 24'hFFFFFF, 1'b1}, // R8
    '{8'h55, 12'hABC, 12'h123, 8'h5A, 8'hC3, 8'h96, 24'h000000, 24'h000000, 24'h000000, 1'b0}, // R10
    '{8'h00, 12'h0FF, 12'h000, 8'h00, 8'h00, 8'h00, 24'h000000, 24'h00FF00, 24'h00FF00, 1'b0}  // R2
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    // R1: reset state
    step(); step();
    chk("R1 oe", oe, 0); chk("R1 bus", bus, 0); chk("R1 pclk", pclk, 0);
    chk("R1 syncs", {de_q, hs_q, vs_q}, 0);
    rst_n = 1'b1;
    sel = 8'h40; r = 8'hFF;
    step(); step();
    chk("R1 idle oe before DE", oe, 0);
    chk("R1 idle bus before DE", bus, 0);

    for (int i = 0; i < NV; i++) begin
      de = 1'b0; sel = VECS[i].code;
      step();
      de = 1'b1;
      y = VECS[i].y; c = VECS[i].c; r = VECS[i].r; g = VECS[i].g; b = VECS[i].b;
      step();
      chk($sformatf("R2-map even code %h", VECS[i].code), bus, VECS[i].e0);
      chk($sformatf("R13 oe code %h", VECS[i].code), oe, VECS[i].eoe);
      chk($sformatf("R7 pclk even code %h", VECS[i].code), pclk, VECS[i].ep);
      chk("R13 idle bits zero", bus & ~oe, 0);
      chk("R12 de_o", de_q, 1);
      step();
      chk($sformatf("R2-map odd code %h", VECS[i].code), bus, VECS[i].e1);
      chk($sformatf("R9 pclk odd code %h", VECS[i].code), pclk, 0);
    end

    // R11: code change mid-line and during blanking waits for DE rise
    de = 1'b0; sel = 8'h40; step();
    de = 1'b1; step();
    chk("R11 new mode at rise", oe, 24'hFFFFFF);
    sel = 8'h00; step();
    chk("R11 mid-line change ignored", oe, 24'hFFFFFF);
    de = 1'b0; step();
    chk("R11 blanking change ignored", oe, 24'hFFFFFF);
    de = 1'b1; step();
    chk("R11 change applied at rise", oe, 24'h00FF00);
    // R10: invalid code
    de = 1'b0; sel = 8'h55; step();
    chk("R10 before rise", oe, 24'h00FF00);
    de = 1'b1; step();
    chk("R10 oe off", oe, 0);
    chk("R10 bus off", bus, 0);

    // R8: distinct even/odd pixels in double-rate RGB
    de = 1'b0; sel = 8'h60; step();
    de = 1'b1; r = 8'h01; g = 8'h02; b = 8'h03; step();
    chk("R8 even pixel", bus, 24'h010203); chk("R8 pclk even", pclk, 1);
    r = 8'h04; g = 8'h05; b = 8'h06; step();
    chk("R8 odd pixel", bus, 24'h040506); chk("R8 pclk odd", pclk, 0);
    step();
    chk("R8 pclk next even", pclk, 1);

    // R14: realign after 1- and 2-cycle blanking
    sel = 8'h20; y = 12'h0A5; c = 12'h03C;
    for (int gap = 1; gap <= 2; gap++) begin
      de = 1'b0;
      repeat (gap) step();
      de = 1'b1; step();
      chk($sformatf("R14 chroma first gap %0d", gap), bus, 24'h003C00);
      chk($sformatf("R14 pclk high gap %0d", gap), pclk, 1);
      step();
      chk($sformatf("R14 luma second gap %0d", gap), bus, 24'h00A500);
    end

    // R12: one-cycle sync pulses
    hs = 1'b1; vs = 1'b0; step();
    chk("R12 hs delayed", {hs_q, vs_q}, 2'b10);
    hs = 1'b0; vs = 1'b1; step();
    chk("R12 vs delayed", {hs_q, vs_q}, 2'b01);
    vs = 1'b0; de = 1'b0; step();
    chk("R12 all low", {de_q, hs_q, vs_q}, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule